// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time-of-Day Counter

This block keeps a 64-bit count of nanoseconds for a precision time protocol clock. A 32-bit phase accumulator adds a programmable addend on every cycle of the reference clock. Each time the accumulator carries out of its top bit, the time counter advances by a programmable nominal period in nanoseconds. The addend sets the long-run rate as a fraction of the reference clock. Software can rewrite the addend while the timer runs, which trims the frequency by parts per billion without a step in time.

Software reaches the block through a small 32-bit register port. Through it, software reads and writes the counter as two words, programs the addend, reads the accumulator, sets a 64-bit time offset, and sets the control fields: enable, soft reset, bypass, tick period and a stored clock-select code. Word-coherent access works in two directions. A low-word read freezes the high word for the read that follows. A low-word write is held until the high-word write commits all 64 bits at once. The offset-corrected time is also driven continuously on an output port.

Top module: `tod_timer`

## Requirements
- R1: After reset, every register reads zero (control, counter words, addend, accumulator, offset words) and `todNs` is zero. Register addresses: 0 control, 1 counter low, 2 counter high, 3 addend, 4 accumulator, 5 offset low, 6 offset high.
- R2: A write to address 1 only stages the low word and leaves the counter unchanged. A write to address 2 loads {written high, staged low} into the counter at that clock edge.
- R3: A read returns its data on `regRdData` one cycle after the strobe. Reading address 1 returns the counter's low word and captures the counter's high word at the same edge. Reading address 2 returns that captured high word.
- R4: On each enabled cycle without bypass, the accumulator adds the addend modulo 2^32. The counter advances by the period field exactly on the cycles where that add carries out of bit 31.
- R5: With bypass set (control bit 3) and the timer enabled, the counter advances by the period field on every cycle.
- R6: While enable (control bit 2) is clear, the counter and the accumulator hold their values.
- R7: Writing control with bit 5 set clears the counter and the accumulator at that edge. The addend and offset are kept, the other control fields take the written value, and bit 5 reads back as zero.
- R8: Rewriting the addend (address 3) does not pause counting. The old addend applies on the write's own edge and the new one from the next edge.
- R9: The control register stores the tick period at bits 25:16, bypass at bit 3, enable at bit 2 and clock select at bits 1:0. It reads back these fields, with all other bits zero. Clock select has no effect on counting.
- R10: `todNs` equals the counter plus the 64-bit offset (high word at address 6, low word at address 5), with the carry passing across the word boundary.
- R11: The accumulator is readable at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after the read strobe |
| todNs | output | 64 | Counter plus offset, in nanoseconds |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is registered and is due one cycle after the strobe. The counter and `todNs` reflect a write or a count step at the edge itself. Because the enable field also updates at the edge of its own write, counting covers the edges after the enabling write, up to and including the edge of the disabling write. The expected nanoseconds and accumulator residue are computed from that count. All inputs are driven and all outputs sampled on the falling edge, so each check reads the value settled after the edge it targets.

// File: rtl/tod_timer_pkg.sv
package tod_timer_pkg;
  localparam int CNT_W    = 64;
  localparam int WORD_W   = 32;
  localparam int ACC_W    = 32;
  localparam int PERIOD_W = 10;
  localparam int PER_LSB  = 16;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTLO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTHI = 3'd2;
  localparam logic [ADDR_W-1:0] A_ADD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACC   = 3'd4;
  localparam logic [ADDR_W-1:0] A_OFFLO = 3'd5;
  localparam logic [ADDR_W-1:0] A_OFFHI = 3'd6;

  localparam int BIT_EN   = 2;
  localparam int BIT_BYP  = 3;
  localparam int BIT_SRST = 5;

  typedef struct packed {
    logic             softRst;
    logic             load;
    logic [CNT_W-1:0] loadVal;
  } tod_strobe_t;
endpackage

// File: rtl/tod_timer_regs.sv
module tod_timer_regs
  import tod_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [CNT_W-1:0]    cntIn,
  input  logic [ACC_W-1:0]    accIn,
  output tod_strobe_t         strobe,
  output logic                enable,
  output logic                bypass,
  output logic [PERIOD_W-1:0] period,
  output logic [ACC_W-1:0]    addend,
  output logic [CNT_W-1:0]    offset,
  output logic [WORD_W-1:0]   rdData
);
  logic [1:0]        clkSel;
  logic [WORD_W-1:0] stagedLo;
  logic [WORD_W-1:0] hiSnap;
  logic [WORD_W-1:0] ctrlView;
  logic              wrCtrl;
  logic              rdLo;

  assign wrCtrl   = wrEn && (addr == A_CTRL);
  assign rdLo     = rdEn && (addr == A_CNTLO);
  assign ctrlView = {6'd0, period, 10'd0, 2'b00, bypass, enable, clkSel};

  always_comb begin
    strobe.softRst = wrCtrl && wrData[BIT_SRST];
    strobe.load    = wrEn && (addr == A_CNTHI);
    strobe.loadVal = {wrData, stagedLo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      bypass   <= 1'b0;
      period   <= '0;
      clkSel   <= '0;
      addend   <= '0;
      offset   <= '0;
      stagedLo <= '0;
    end else if (wrEn) begin
      unique case (addr)
        A_CTRL: begin
          enable <= wrData[BIT_EN];
          bypass <= wrData[BIT_BYP];
          period <= wrData[PER_LSB +: PERIOD_W];
          clkSel <= wrData[1:0];
        end
        A_CNTLO: stagedLo <= wrData;
        A_ADD:   addend <= wrData;
        A_OFFLO: offset[WORD_W-1:0] <= wrData;
        A_OFFHI: offset[CNT_W-1:WORD_W] <= wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiSnap <= '0;
      rdData <= '0;
    end else if (rdEn) begin
      if (rdLo) hiSnap <= cntIn[CNT_W-1:WORD_W];
      unique case (addr)
        A_CTRL:  rdData <= ctrlView;
        A_CNTLO: rdData <= cntIn[WORD_W-1:0];
        A_CNTHI: rdData <= hiSnap;
        A_ADD:   rdData <= addend;
        A_ACC:   rdData <= accIn;
        A_OFFLO: rdData <= offset[WORD_W-1:0];
        A_OFFHI: rdData <= offset[CNT_W-1:WORD_W];
        default: rdData <= '0;
      endcase
    end
  end

  // R3: a low-word read freezes the live high word
  a_r3_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    rdLo |=> hiSnap == $past(cntIn[CNT_W-1:WORD_W]));

  // R7: the soft-reset bit never reads back as set
  a_r7_srst_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && addr == A_CTRL |=> !rdData[BIT_SRST]);
endmodule

// File: rtl/tod_timer_core.sv
module tod_timer_core
  import tod_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tod_strobe_t         strobe,
  input  logic                enable,
  input  logic                bypass,
  input  logic [PERIOD_W-1:0] period,
  input  logic [ACC_W-1:0]    addend,
  output logic [CNT_W-1:0]    cnt,
  output logic [ACC_W-1:0]    acc
);
  logic [ACC_W:0]   accSum;
  logic             carry;
  logic [CNT_W-1:0] cntStep;

  assign accSum  = {1'b0, acc} + {1'b0, addend};
  assign carry   = accSum[ACC_W];
  assign cntStep = cnt + CNT_W'(period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      acc <= '0;
    end else if (strobe.softRst) begin
      cnt <= '0;
      acc <= '0;
    end else if (strobe.load) begin
      cnt <= strobe.loadVal;
    end else if (enable) begin
      acc <= accSum[ACC_W-1:0];
      if (bypass || carry) cnt <= cntStep;
    end
  end

  // R2: a high-word write commits the whole 64-bit value
  a_r2_commit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.softRst |=> cnt == $past(strobe.loadVal));

  // R6: disabled timer holds counter and accumulator
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !strobe.load && !strobe.softRst |=> $stable(cnt) && $stable(acc));

  // R7: soft reset clears counter and accumulator
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |=> cnt == '0 && acc == '0);

  // R4: without bypass the counter stays or moves by exactly one period
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    enable && !bypass && !strobe.load && !strobe.softRst |=>
      (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'($past(period))));

  // R5: bypass advances on every enabled cycle
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rstN)
    enable && bypass && !strobe.load && !strobe.softRst |=>
      cnt == $past(cnt) + CNT_W'($past(period)));
endmodule

// File: rtl/tod_timer.sv
module tod_timer
  import tod_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [63:0]       todNs
);
  tod_strobe_t         strobe;
  logic                enable;
  logic                bypass;
  logic [PERIOD_W-1:0] period;
  logic [ACC_W-1:0]    addend;
  logic [CNT_W-1:0]    offset;
  logic [CNT_W-1:0]    cnt;
  logic [ACC_W-1:0]    acc;

  tod_timer_regs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .rdEn   (regRdEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .cntIn  (cnt),
    .accIn  (acc),
    .strobe (strobe),
    .enable (enable),
    .bypass (bypass),
    .period (period),
    .addend (addend),
    .offset (offset),
    .rdData (regRdData)
  );

  tod_timer_core u_core (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .enable (enable),
    .bypass (bypass),
    .period (period),
    .addend (addend),
    .cnt    (cnt),
    .acc    (acc)
  );

  assign todNs = cnt + offset;
endmodule

// File: tb/tod_timer_bench.sv
module tod_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] todNs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_timer u_tod_timer (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .todNs     (todNs)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "todNs", todNs, 64'h0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1", $sformatf("reg %0d", a), {32'h0, v}, 64'h0);
    end
  endtask

  task automatic t_stage_commit();
    logic [31:0] v;
    wr(3'd1, 32'h1234_5678);
    check("R2", "after low write only", todNs, 64'h0);
    wr(3'd2, 32'h0000_0009);
    check("R2", "after high write", todNs, 64'h9_1234_5678);
    idle(10);
    check("R6", "disabled hold", todNs, 64'h9_1234_5678);
    rd(3'd4, v);
    check("R6", "acc held", {32'h0, v}, 64'h0);
  endtask

  task automatic t_fraction();
    logic [31:0] v;
    wr(3'd0, 32'h0008_0020);
    check("R7", "soft reset clears", todNs, 64'h0);
    wr(3'd3, 32'h5000_0000);
    wr(3'd0, 32'h0008_0004);
    idle(39);
    wr(3'd0, 32'h0008_0000);
    // 40 adds of 5/16: 12 carries, residue one half
    check("R4", "fractional count", todNs, 64'd96);
    rd(3'd4, v);
    check("R11", "acc residue", {32'h0, v}, 64'h8000_0000);
    idle(5);
    check("R6", "hold after disable", todNs, 64'd96);
  endtask

  task automatic t_rewrite();
    logic [31:0] v;
    wr(3'd0, 32'h0005_0020);
    wr(3'd3, 32'h4000_0000);
    wr(3'd0, 32'h0005_0004);
    idle(7);
    wr(3'd3, 32'h8000_0000);
    idle(3);
    wr(3'd0, 32'h0005_0000);
    // 8 adds of 1/4 then 4 adds of 1/2: 4 carries of 5 ns
    check("R8", "count across addend rewrite", todNs, 64'd20);
    rd(3'd4, v);
    check("R8", "acc after rewrite", {32'h0, v}, 64'h0);
  endtask

  task automatic t_bypass();
    wr(3'd0, 32'h0003_0020);
    wr(3'd0, 32'h0003_000C);
    idle(9);
    wr(3'd0, 32'h0003_0000);
    check("R5", "bypass count", todNs, 64'd30);
  endtask

  task automatic t_keep_config();
    logic [31:0] v;
    wr(3'd5, 32'h0000_0100);
    wr(3'd6, 32'h0000_0002);
    wr(3'd0, 32'h0003_0021);
    check("R7", "offset kept, counter cleared", todNs, 64'h2_0000_0100);
    rd(3'd0, v);
    check("R7", "ctrl readback, reset bit zero", {32'h0, v}, 64'h0003_0001);
    rd(3'd3, v);
    check("R7", "addend kept", {32'h0, v}, 64'h8000_0000);
    rd(3'd4, v);
    check("R7", "acc cleared", {32'h0, v}, 64'h0);
    rd(3'd5, v);
    check("R10", "offset low readback", {32'h0, v}, 64'h100);
    rd(3'd6, v);
    check("R10", "offset high readback", {32'h0, v}, 64'h2);
  endtask

  task automatic t_offset_carry();
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0);
    wr(3'd5, 32'h1);
    wr(3'd6, 32'h0);
    check("R10", "offset carry into high word", todNs, 64'h1_0000_0000);
    wr(3'd5, 32'h0);
    check("R10", "zero offset", todNs, 64'h0_FFFF_FFFF);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFDA);
    rd(3'd0, v);
    check("R9", "ctrl fields", {32'h0, v}, 64'h03FF_000A);
    check("R9", "clock select and bypass without enable", todNs, 64'h0_FFFF_FFFF);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_snapshot();
    logic [31:0] v;
    wr(3'd0, 32'h0001_000C);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'h0000_0001);
    rd(3'd1, v);
    check("R3", "low word read", {32'h0, v}, 64'hFFFF_FFF0);
    idle(20);
    rd(3'd2, v);
    check("R3", "high word coherent", {32'h0, v}, 64'h1);
    check("R3", "live counter past wrap", todNs, 64'h2_0000_0006);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_commit();
    t_fraction();
    t_rewrite();
    t_bypass();
    t_keep_config();
    t_offset_carry();
    t_ctrl_fields();
    t_snapshot();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule